// File: doc/BRIEF.md
# Security State Controller

This block holds the security posture of a chip as a five-state machine and makes it visible through two 32-bit registers. Software writes a command register to ask for a state change or to report a security violation. It reads a status register to learn the current state as a 4-bit code. Two sticky lock bits in the command register can block particular transitions. Once a lock bit is set, only a reset clears it.

The state starts in check. A request moves check to trusted and trusted to secure. It moves secure back to trusted unless that step is locked. It moves soft-fail to non-secure unless that step is locked. An ordinary violation pushes a trusted or secure chip into soft-fail, and a chip still in check into non-secure. A fatal violation forces soft-fail from any state. Once the chip is in soft-fail or non-secure, it can never reach trusted or secure again.

Top module: `sec_state_ctrl`

## Requirements
- R1: After reset the state is check (code 0x9), both lock bits are 0, the status register reads 0x0000_0900 and the command register reads 0.
- R2: The status register at offset 0x14 reports the state in bits [11:8], with all other bits 0. The codes are check 0x9, non-secure 0xB, trusted 0xD, secure 0xF and soft-fail 0x3. The state_o port carries the same code.
- R3: The command register is at offset 0x04. Bit 0 is a transition request, bit 8 an ordinary violation and bit 9 a fatal violation. These three bits are one-shot and always read back as 0. A read returns the lock bits in positions 1 and 2 and 0 in every other bit.
- R4: From check, a request moves the state to trusted, and an ordinary violation moves it to non-secure.
- R5: From trusted, a request moves the state to secure. From trusted or secure, an ordinary violation moves the state to soft-fail.
- R6: From secure, a request moves the state to trusted only while lock bit 1 is clear. Otherwise the state stays secure.
- R7: From soft-fail, a request moves the state to non-secure only while lock bit 2 is clear. Otherwise the state stays soft-fail.
- R8: A fatal violation moves any state to soft-fail.
- R9: Writing 1 to command bit 1 or bit 2 sets that lock until reset. Writing 0 leaves it set. A lock set by a write already applies to a request carried in the same write.
- R10: When one write carries several events, the fatal violation wins over the ordinary violation, and the ordinary violation wins over the request.
- R11: The state changes at the first clock edge that samples the command write. Writes to any other offset, including the status offset, change nothing.
- R12: From non-secure, requests and ordinary violations leave the state unchanged. No path leads from soft-fail or non-secure to trusted or secure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe, sampled at the rising edge |
| addr_i | input | ADDR_W (8) | Byte offset of the register access |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for addr_i, combinational |
| state_o | output | 4 | Current state code |

## Verification
The bench drives the gated exits with their locks both set and clear. A design that ignored bit 1 or bit 2 would leave secure or soft-fail when it must stay. It also sets a lock and issues a request in the same write, which catches a lock that takes effect one cycle late. It sends combined events in one write to check the priority order: a design that let a request beat a violation would go from check to trusted where non-secure is expected. It requests and violates from non-secure and soft-fail, which exposes any path back to trusted. It writes 0 to a set lock and reads the command register back, which exposes locks that can be cleared and one-shot bits that stay stuck.

// File: rtl/sec_state_pkg.sv
package sec_state_pkg;
  typedef enum logic [3:0] {
    ST_CHECK    = 4'h9,
    ST_NONSEC   = 4'hB,
    ST_TRUST    = 4'hD,
    ST_SECURE   = 4'hF,
    ST_SOFTFAIL = 4'h3
  } sec_state_e;

  localparam int CMD_OFFSET  = 'h04;
  localparam int STAT_OFFSET = 'h14;

  localparam int CMD_REQ_BIT    = 0;
  localparam int CMD_ST_DIS_BIT = 1;
  localparam int CMD_SF_DIS_BIT = 2;
  localparam int CMD_SV_BIT     = 8;
  localparam int CMD_FSV_BIT    = 9;
  localparam int STAT_LSB       = 8;
  localparam int STATE_W        = 4;
endpackage

// File: rtl/sec_state_cmd.sv
module sec_state_cmd
  import sec_state_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              req_o,
  output logic              sv_o,
  output logic              fsv_o,
  output logic              st_dis_eff_o,
  output logic              sf_dis_eff_o,
  output logic              st_dis_q_o,
  output logic              sf_dis_q_o
);
  logic cmd_wr;
  logic st_dis_q, sf_dis_q;
  logic unused_wdata;

  assign cmd_wr = we_i && (addr_i == ADDR_W'(CMD_OFFSET));
  assign req_o  = cmd_wr && wdata_i[CMD_REQ_BIT];
  assign sv_o   = cmd_wr && wdata_i[CMD_SV_BIT];
  assign fsv_o  = cmd_wr && wdata_i[CMD_FSV_BIT];

  // a lock set in this write already gates the request in the same write
  assign st_dis_eff_o = st_dis_q || (cmd_wr && wdata_i[CMD_ST_DIS_BIT]);
  assign sf_dis_eff_o = sf_dis_q || (cmd_wr && wdata_i[CMD_SF_DIS_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_dis_q <= 1'b0;
      sf_dis_q <= 1'b0;
    end else begin
      st_dis_q <= st_dis_eff_o;
      sf_dis_q <= sf_dis_eff_o;
    end
  end

  assign st_dis_q_o   = st_dis_q;
  assign sf_dis_q_o   = sf_dis_q;
  assign unused_wdata = ^wdata_i;

  assert_lock_st_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_dis_q |=> st_dis_q);
  assert_lock_sf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sf_dis_q |=> sf_dis_q);
  assert_lock_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[CMD_ST_DIS_BIT]) |=> st_dis_q);
endmodule

// File: rtl/sec_state_fsm.sv
module sec_state_fsm
  import sec_state_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       sv_i,
  input  logic       fsv_i,
  input  logic       st_dis_i,
  input  logic       sf_dis_i,
  output sec_state_e state_o
);
  sec_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (fsv_i) begin
      state_d = ST_SOFTFAIL;
    end else if (sv_i) begin
      case (state_q)
        ST_CHECK:            state_d = ST_NONSEC;
        ST_TRUST, ST_SECURE: state_d = ST_SOFTFAIL;
        default:             state_d = state_q;
      endcase
    end else if (req_i) begin
      case (state_q)
        ST_CHECK:    state_d = ST_TRUST;
        ST_TRUST:    state_d = ST_SECURE;
        ST_SECURE:   if (!st_dis_i) state_d = ST_TRUST;
        ST_SOFTFAIL: if (!sf_dis_i) state_d = ST_NONSEC;
        default:     state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_CHECK;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_legal_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q inside {ST_CHECK, ST_NONSEC, ST_TRUST, ST_SECURE, ST_SOFTFAIL});
  assert_fatal_softfail_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsv_i |=> state_q == ST_SOFTFAIL);
  assert_no_return_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NONSEC || state_q == ST_SOFTFAIL)
      |=> !(state_q == ST_TRUST || state_q == ST_SECURE));
  assert_hold_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i || sv_i || fsv_i) |=> $stable(state_q));
  assert_secure_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SECURE && req_i && !sv_i && !fsv_i && st_dis_i) |=> state_q == ST_SECURE);
  assert_softfail_lock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SOFTFAIL && !fsv_i && sf_dis_i) |=> state_q == ST_SOFTFAIL);
endmodule

// File: rtl/sec_state_rdmux.sv
module sec_state_rdmux
  import sec_state_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic               st_dis_i,
  input  logic               sf_dis_i,
  output logic [DATA_W-1:0]  rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(CMD_OFFSET)) begin
      rdata_o[CMD_ST_DIS_BIT] = st_dis_i;
      rdata_o[CMD_SF_DIS_BIT] = sf_dis_i;
    end else if (addr_i == ADDR_W'(STAT_OFFSET)) begin
      rdata_o[STAT_LSB +: STATE_W] = state_i;
    end
  end

  always_comb begin
    assert_cmd_pulses_zero_R3: assert (!(addr_i == ADDR_W'(CMD_OFFSET)) ||
      (rdata_o[CMD_REQ_BIT] == 1'b0 && rdata_o[CMD_SV_BIT] == 1'b0 && rdata_o[CMD_FSV_BIT] == 1'b0));
  end
endmodule

// File: rtl/sec_state_ctrl.sv
module sec_state_ctrl
  import sec_state_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [3:0]        state_o
);
  logic req, sv, fsv, st_dis_eff, sf_dis_eff, st_dis_q, sf_dis_q;
  sec_state_e state;

  sec_state_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .req_o(req), .sv_o(sv), .fsv_o(fsv),
    .st_dis_eff_o(st_dis_eff), .sf_dis_eff_o(sf_dis_eff),
    .st_dis_q_o(st_dis_q), .sf_dis_q_o(sf_dis_q)
  );

  sec_state_fsm u_fsm (
    .clk_i, .rst_ni, .req_i(req), .sv_i(sv), .fsv_i(fsv),
    .st_dis_i(st_dis_eff), .sf_dis_i(sf_dis_eff), .state_o(state)
  );

  sec_state_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .addr_i, .state_i(state), .st_dis_i(st_dis_q), .sf_dis_i(sf_dis_q), .rdata_o
  );

  assign state_o = state;
endmodule

// File: tb/tb_sec_state_ctrl.sv
module tb_sec_state_ctrl;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        we_i = 0;
  logic [7:0]  addr_i = 0;
  logic [31:0] wdata_i = 0;
  logic [31:0] rdata_o;
  logic [3:0]  state_o;
  int checks = 0, errors = 0;

  localparam logic [3:0] CHK = 4'h9, NS = 4'hB, TR = 4'hD, SE = 4'hF, SF = 4'h3;

  sec_state_ctrl dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 0; we_i = 0;
    @(negedge clk_i); rst_ni = 1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; we_i = 1;
    @(negedge clk_i); we_i = 0; wdata_i = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i); addr_i = a; #1 d = rdata_o;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1 state", 32'(state_o), 32'(CHK));
    rd(8'h14, d); chk("R1 R2 status", d, 32'h900);
    rd(8'h04, d); chk("R1 cmd", d, 32'h0);
  endtask

  task automatic t_main_path();
    logic [31:0] d;
    do_reset();
    wr(8'h04, 32'h1); chk("R4 check->trusted", 32'(state_o), 32'(TR));
    rd(8'h04, d);     chk("R3 pulse reads 0", d, 32'h0);
    wr(8'h04, 32'h1); chk("R5 trusted->secure", 32'(state_o), 32'(SE));
    rd(8'h14, d);     chk("R2 secure code", d, 32'hF00);
    wr(8'h04, 32'h1); chk("R6 secure->trusted", 32'(state_o), 32'(TR));
    wr(8'h04, 32'h100); chk("R5 trusted sv->softfail", 32'(state_o), 32'(SF));
    wr(8'h04, 32'h1); chk("R7 softfail->nonsec", 32'(state_o), 32'(NS));
    wr(8'h04, 32'h1); chk("R12 nonsec req", 32'(state_o), 32'(NS));
    wr(8'h04, 32'h100); chk("R12 nonsec sv", 32'(state_o), 32'(NS));
    rd(8'h14, d);     chk("R2 nonsec code", d, 32'hB00);
  endtask

  task automatic t_check_sv();
    do_reset();
    wr(8'h04, 32'h100); chk("R4 check sv->nonsec", 32'(state_o), 32'(NS));
    wr(8'h04, 32'h1);   chk("R12 no trusted", 32'(state_o), 32'(NS));
  endtask

  task automatic t_locks();
    logic [31:0] d;
    do_reset();
    wr(8'h04, 32'h1); wr(8'h04, 32'h1);
    wr(8'h04, 32'h100); chk("R5 secure sv->softfail", 32'(state_o), 32'(SF));
    do_reset();
    wr(8'h04, 32'h1); wr(8'h04, 32'h1);
    wr(8'h04, 32'h2); chk("R9 lock write no move", 32'(state_o), 32'(SE));
    rd(8'h04, d);     chk("R9 lock reads back", d, 32'h2);
    wr(8'h04, 32'h0); rd(8'h04, d); chk("R9 lock ignores 0", d, 32'h2);
    wr(8'h04, 32'h1); chk("R6 locked secure stays", 32'(state_o), 32'(SE));
    wr(8'h04, 32'h100); chk("R5 secure sv", 32'(state_o), 32'(SF));
    wr(8'h04, 32'h5); chk("R9 R7 lock same write", 32'(state_o), 32'(SF));
    rd(8'h04, d);     chk("R9 both locks", d, 32'h6);
    wr(8'h04, 32'h1); chk("R7 locked softfail stays", 32'(state_o), 32'(SF));
  endtask

  task automatic t_fatal_priority();
    do_reset();
    wr(8'h04, 32'h200); chk("R8 fatal from check", 32'(state_o), 32'(SF));
    do_reset();
    wr(8'h04, 32'h101); chk("R10 sv beats req", 32'(state_o), 32'(NS));
    wr(8'h04, 32'h200); chk("R8 fatal from nonsec", 32'(state_o), 32'(SF));
    do_reset();
    wr(8'h04, 32'h1);
    wr(8'h04, 32'h301); chk("R10 fatal wins", 32'(state_o), 32'(SF));
    do_reset();
    wr(8'h04, 32'h300); chk("R10 fatal beats sv", 32'(state_o), 32'(SF));
  endtask

  task automatic t_addr_timing();
    do_reset();
    wr(8'h14, 32'h1);   chk("R11 status write ignored", 32'(state_o), 32'(CHK));
    wr(8'h08, 32'h301); chk("R11 other offset ignored", 32'(state_o), 32'(CHK));
    @(negedge clk_i); addr_i = 8'h04; wdata_i = 32'h1; we_i = 0;
    @(negedge clk_i); chk("R11 no strobe no change", 32'(state_o), 32'(CHK));
    we_i = 1; #1 chk("R11 before edge", 32'(state_o), 32'(CHK));
    @(posedge clk_i); #1 chk("R11 after edge", 32'(state_o), 32'(TR));
    @(negedge clk_i); we_i = 0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_main_path();
        t_check_sv();
        t_locks();
        t_fatal_priority();
        t_addr_timing();
      end
      begin
        repeat (20000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule